// File: doc/BRIEF.md
# Cascadable Paged Serial Configuration Reader

This block is the read side of a serial configuration memory. It feeds a stored bitstream to an FPGA one bit per clock. Words are read from a synchronous word store and shifted out most significant bit first. A word-address counter and a bit counter walk through either the whole store or one of four equal quarter pages. The page is chosen by a page-enable input and a two-bit page select, and both are captured while the combined reset/output-enable input is low.

When the last bit of the active range has been sent, the block stops driving its data line. It then pulls its cascade chip-enable output low. That output wires straight to the chip-enable input of the next device in a chain, so the next device continues the stream on the following clock. A serial-mode enable input selects programming mode when low. In that mode the read path is frozen and silent, and a raw word write port stands in for the programming interface.

The data line is modelled as a data bit plus a separate drive-enable, not as a real tri-state. The production configuration uses a 20-bit word address and 16-bit words. The defaults are smaller so that the model stays light.

Top module: `cfg_serial_reader`

## Requirements
- R1: While `serEn` is high and `rstOeN` is low, on every clock the bit counter clears and the word address loads the page base. The page base is `pageSel` × 2^(ADDR_W-2) when `pageEn` is high and 0 otherwise. The completion state clears. `dataOe` is low and `ceoN` is high whatever `ceN` is.
- R2: While `serEn` and `rstOeN` are high, `ceN` is low and the range is not finished, `dataOe` is high and `dataBit` shows the bit selected by the bit counter. Each clock advances the bit counter. Bit WORD_W-1 of a word is sent first and bit 0 last, and the word address increments after bit 0.
- R3: While `ceN` is high, both counters hold and `dataOe` is low.
- R4: With `pageEn` high at reset, the words read are base .. base+2^(ADDR_W-2)-1. With it low, the words read are 0 .. 2^ADDR_W-1. Changes to `pageEn` or `pageSel` after reset have no effect until the next reset.
- R5: On the clock that consumes bit 0 of the last word of the active range, `dataOe` drops, and it stays low until the next reset. From then on `ceoN` is low while `ceN` is low and `rstOeN` is high.
- R6: After completion, `ceoN` follows `ceN` while `rstOeN` stays high. Once `rstOeN` goes low, `ceoN` stays high until the range has been read to its end again.
- R7: While `serEn` is low, `dataOe` is low and `ceoN` is high. The counters and the captured page do not change, and `ceN`, `rstOeN`, `pageEn` and `pageSel` are ignored. On a return of `serEn` to high, the first clock is spent refetching the current word, and the stream then resumes at the next unsent bit.
- R8: Power-on reset (`porN` low) sets the word address and bit counter to 0, selects the full unpaged range and clears the completion state.
- R9: `wrEn` writes `wrData` into word `wrAddr` only while `serEn` is low. While `serEn` is high, a write has no effect on the data streamed.
- R10: When two blocks are chained (`ceoN` of the first to `ceN` of the second) and share `rstOeN`, the bits from the two blocks form a single stream. That stream is the first block's range followed directly by the second block's range, and at no cycle do both blocks drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; each rising edge with reading enabled consumes one bit |
| porN | input | 1 | Asynchronous power-on reset, active low |
| serEn | input | 1 | High: read mode; low: programming mode |
| ceN | input | 1 | Chip enable, active low |
| rstOeN | input | 1 | Low: reset counters; high: output enable |
| pageEn | input | 1 | Partition the store into four pages, captured at reset |
| pageSel | input | 2 | Page number, captured at reset |
| wrEn | input | 1 | Word write strobe, honoured in programming mode only |
| wrAddr | input | ADDR_W | Word address for a write |
| wrData | input | WORD_W | Word value for a write |
| dataBit | output | 1 | Serial data value |
| dataOe | output | 1 | High when this block drives the data line |
| ceoN | output | 1 | Cascade chip enable for the next device, active low |

## Verification
Assertions check several rules on every cycle: a reset leaves the counters at a page base; the address never leaves the captured page; the counters hold when neither stepping nor loading; the bit counter steps by one inside a word; completion is sticky until reset; `ceoN` low never coincides with driving the data line; and programming mode is silent. What only the bench's scenarios can show is the content and order of the stream. That covers each of the four pages and the full range, the resumption after a standby pause and after a trip through programming mode, writes and page changes that are ignored, the exact hand-off to a second chained device with no gap or overlap, and the behaviour of `ceoN` after completion.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;   // reload counters to the page base, capture page
    logic step;   // consume the current bit this clock
  } strobe_t;

endpackage

// File: rtl/cfgrd_store.sv
module cfgrd_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              serEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Writes only in programming mode (R9); read is registered every cycle.
  always_ff @(posedge clk) begin
    if (wrEn && !serEn) mem[wrAddr] <= wrData;
    rdWord <= mem[rdAddr];
  end

endmodule

// File: rtl/cfgrd_ctrl.sv
module cfgrd_ctrl
  import cfgrd_pkg::*;
(
  input  logic    clk,
  input  logic    porN,
  input  logic    serEn,
  input  logic    ceN,
  input  logic    rstOeN,
  input  logic    atEnd,
  output strobe_t str,
  output logic    dataOe,
  output logic    ceoN
);
  logic done;     // active range fully sent
  logic primed;   // store output matches current address

  always_comb begin
    str.load = serEn && !rstOeN;
    str.step = serEn && rstOeN && !ceN && primed && !done;
    dataOe   = str.step;
    ceoN     = !(serEn && rstOeN && !ceN && done);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      done   <= 1'b0;
      primed <= 1'b0;
    end else begin
      primed <= serEn;
      if (str.load)                done <= 1'b0;
      else if (str.step && atEnd)  done <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (done && !str.load) |=> done);                                   // R6
  AST_END_RELEASES_LINE: assert property (@(posedge clk) disable iff (!porN)
    (str.step && atEnd) |=> !dataOe);                                // R5
  AST_CEO_EXCLUDES_DATA: assert property (@(posedge clk) disable iff (!porN)
    !ceoN |-> !dataOe);                                              // R5

endmodule

// File: rtl/cfgrd_datapath.sv
module cfgrd_datapath
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  strobe_t           str,
  input  logic              pageEn,
  input  logic [1:0]        pageSel,
  input  logic [WORD_W-1:0] curWord,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              dataBit,
  output logic              atEnd
);
  localparam int OFF_W    = ADDR_W - 2;
  localparam int BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int LAST_BIT = WORD_W - 1;

  logic [ADDR_W-1:0] wordAddr, baseAddr, lastAddr, nextAddr;
  logic [BIT_W-1:0]  bitIdx, nextBit, selIdx;
  logic              pgEnQ;
  logic [1:0]        pgSelQ;
  logic              bitWrap;

  always_comb begin
    baseAddr = pageEn ? {pageSel, {OFF_W{1'b0}}} : '0;
    lastAddr = pgEnQ ? {pgSelQ, {OFF_W{1'b1}}} : {ADDR_W{1'b1}};
    bitWrap  = (bitIdx == BIT_W'(LAST_BIT));
    atEnd    = bitWrap && (wordAddr == lastAddr);

    nextAddr = wordAddr;
    nextBit  = bitIdx;
    if (str.load) begin
      nextAddr = baseAddr;
      nextBit  = '0;
    end else if (str.step) begin
      nextBit = bitWrap ? '0 : bitIdx + 1'b1;
      if (bitWrap && !atEnd) nextAddr = wordAddr + 1'b1;
    end
    rdAddr  = nextAddr;            // prefetch keeps curWord == mem[wordAddr]
    selIdx  = BIT_W'(LAST_BIT) - bitIdx;
    dataBit = curWord[selIdx];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wordAddr <= '0;
      bitIdx   <= '0;
      pgEnQ    <= 1'b0;
      pgSelQ   <= 2'b00;
    end else begin
      wordAddr <= nextAddr;
      bitIdx   <= nextBit;
      if (str.load) begin
        pgEnQ  <= pageEn;
        pgSelQ <= pageSel;
      end
    end
  end

  AST_LOAD_TO_BASE: assert property (@(posedge clk) disable iff (!porN)
    str.load |=> (bitIdx == '0) && (wordAddr[OFF_W-1:0] == '0));      // R1
  AST_STAY_IN_PAGE: assert property (@(posedge clk) disable iff (!porN)
    pgEnQ |-> (wordAddr[ADDR_W-1 -: 2] == pgSelQ));                   // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!porN)
    (!str.load && !str.step) |=> ($stable(wordAddr) && $stable(bitIdx))); // R3
  AST_BIT_ORDER: assert property (@(posedge clk) disable iff (!porN)
    (str.step && !bitWrap) |=>
      ((bitIdx == BIT_W'($past(bitIdx) + 1'b1)) && $stable(wordAddr))); // R2

endmodule

// File: rtl/cfg_serial_reader.sv
module cfg_serial_reader
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              serEn,
  input  logic              ceN,
  input  logic              rstOeN,
  input  logic              pageEn,
  input  logic [1:0]        pageSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic              dataBit,
  output logic              dataOe,
  output logic              ceoN
);
  strobe_t           str;
  logic              atEnd;
  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] curWord;

  cfgrd_ctrl i_ctrl (
    .clk(clk), .porN(porN), .serEn(serEn), .ceN(ceN), .rstOeN(rstOeN),
    .atEnd(atEnd), .str(str), .dataOe(dataOe), .ceoN(ceoN)
  );

  cfgrd_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_dp (
    .clk(clk), .porN(porN), .str(str), .pageEn(pageEn), .pageSel(pageSel),
    .curWord(curWord), .rdAddr(rdAddr), .dataBit(dataBit), .atEnd(atEnd)
  );

  cfgrd_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_store (
    .clk(clk), .serEn(serEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdWord(curWord)
  );

  AST_PROG_MODE_SILENT: assert property (@(posedge clk) disable iff (!porN)
    !serEn |-> (!dataOe && ceoN));                                   // R7

endmodule

// File: tb/test_cfg_serial_reader.sv
module test_cfg_serial_reader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int WW = 4;
  localparam int NWORDS = 1 << AW;
  localparam int QWORDS = NWORDS / 4;

  logic clk, porN, serEn, ceA, rstOeN, pageEn, wrEnA, wrEnB;
  logic [1:0] pageSel;
  logic [AW-1:0] wrAddr;
  logic [WW-1:0] wrData;
  logic bitA, oeA, ceoA, bitB, oeB, ceoB;
  int checks = 0, errors = 0, cyc = 0;

  cfg_serial_reader #(.ADDR_W(AW), .WORD_W(WW)) i_cfg_serial_reader (
    .clk(clk), .porN(porN), .serEn(serEn), .ceN(ceA), .rstOeN(rstOeN),
    .pageEn(pageEn), .pageSel(pageSel), .wrEn(wrEnA), .wrAddr(wrAddr),
    .wrData(wrData), .dataBit(bitA), .dataOe(oeA), .ceoN(ceoA));

  cfg_serial_reader #(.ADDR_W(AW), .WORD_W(WW)) i_second (
    .clk(clk), .porN(porN), .serEn(serEn), .ceN(ceoA), .rstOeN(rstOeN),
    .pageEn(pageEn), .pageSel(pageSel), .wrEn(wrEnB), .wrAddr(wrAddr),
    .wrData(wrData), .dataBit(bitB), .dataOe(oeB), .ceoN(ceoB));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <=20000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [WW-1:0] content(input int dev, input int a);
    return dev == 0 ? WW'((a * 7 + 1) % 16) : WW'((a * 11 + 6) % 16);
  endfunction

  function automatic logic expBit(input int dev, input int idx,
                                  input bit pEn, input logic [1:0] pSel);
    int base = pEn ? int'(pSel) * QWORDS : 0;
    logic [WW-1:0] w = content(dev, base + idx / WW);
    return w[WW - 1 - (idx % WW)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edgeDrive();
    @(posedge clk); #1;
  endtask

  // Reads the chained stream and compares it with both ranges.
  task automatic runChain(input bit doReset, input bit pEn, input logic [1:0] pSel,
                          input int pauseMode, input int pauseAt);
    int len = (pEn ? QWORDS : NWORDS) * WW;
    int got = 0, guard = 0;
    bit paused = 0;
    logic expv;
    if (doReset) begin
      edgeDrive(); rstOeN = 0; ceA = 0; pageEn = pEn; pageSel = pSel;
      @(negedge clk);
      chk(!oeA && !oeB && ceoA, "R1 reset silences", {oeA, oeB, ceoA}, 1);
      edgeDrive(); rstOeN = 1;
    end else begin
      edgeDrive(); ceA = 0;
    end
    while (got < 2 * len && guard < 400) begin
      @(negedge clk);
      guard++;
      chk(!(oeA && oeB), "R10 no overlap", {oeA, oeB}, 0);
      if (oeA || oeB) begin
        if (got < len) begin
          expv = expBit(0, got, pEn, pSel);
          chk(oeA && bitA == expv, "R2 first device bit", bitA, expv);
        end else begin
          expv = expBit(1, got - len, pEn, pSel);
          chk(oeB && bitB == expv, "R10 second device bit", bitB, expv);
          if (got == len) chk(!ceoA && !oeA, "R5 hand-off", ceoA, 0);
        end
        got++;
      end
      if (pauseMode != 0 && !paused && got == pauseAt) begin
        paused = 1;
        if (pauseMode == 1) begin
          // Standby pause with ignored page change and ignored write.
          edgeDrive(); ceA = 1; pageSel = ~pSel; pageEn = ~pEn;
          wrEnA = 1; wrAddr = AW'((pEn ? int'(pSel) * QWORDS : 0) + len / WW - 1);
          wrData = ~content(0, int'(wrAddr));
          @(negedge clk);
          chk(!oeA && !oeB, "R3 standby silent", {oeA, oeB}, 0);
          edgeDrive(); wrEnA = 0;
          @(negedge clk);
          chk(!oeA && !oeB, "R3 standby silent", {oeA, oeB}, 0);
          edgeDrive(); ceA = 0;
        end else begin
          // Programming-mode detour with ignored reset and page change.
          edgeDrive(); serEn = 0; ceA = 1;
          @(negedge clk);
          chk(!oeA && ceoA, "R7 prog silent", {oeA, ceoA}, 1);
          edgeDrive(); rstOeN = 0; pageSel = ~pSel;
          @(negedge clk);
          chk(!oeA && ceoA && !oeB, "R7 prog ignores reset", {oeA, ceoA}, 1);
          edgeDrive(); rstOeN = 1; ceA = 0;
          @(negedge clk);
          chk(!oeA, "R7 prog ignores ce", oeA, 0);
          edgeDrive(); serEn = 1;
        end
      end
    end
    chk(got == 2 * len, "R10 stream length", got, 2 * len);
    repeat (2) begin
      @(negedge clk);
      chk(!oeA && !oeB && !ceoA && !ceoB, "R5 after end", {oeA, oeB, ceoA, ceoB}, 0);
    end
  endtask

  initial begin
    porN = 0; serEn = 1; ceA = 1; rstOeN = 1; pageEn = 0; pageSel = 0;
    wrEnA = 0; wrEnB = 0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    chk(!oeA && ceoA, "R8 power-on state", {oeA, ceoA}, 1);
    edgeDrive(); porN = 1; serEn = 0;
    for (int a = 0; a < NWORDS; a++) begin
      wrEnA = 1; wrAddr = AW'(a); wrData = content(0, a);
      edgeDrive();
      wrEnA = 0; wrEnB = 1; wrData = content(1, a);
      edgeDrive();
      wrEnB = 0;
    end
    serEn = 1;
    // R8: no reset pulse, counters start at word 0 over the full range.
    runChain(0, 0, 2'd0, 0, 0);
    // R4: sweep all four pages.
    for (int s = 0; s < 4; s++) runChain(1, 1, 2'(s), 0, 0);
    // R3 / R9 / R4 ignored inputs during a standby pause.
    runChain(1, 0, 2'd0, 1, 5);
    runChain(1, 1, 2'd1, 1, 3);
    // R7 programming detour.
    runChain(1, 1, 2'd2, 2, 9);
    // R6 cascade output after completion.
    edgeDrive(); ceA = 1;
    @(negedge clk); chk(ceoA && !oeA, "R6 follows ce high", ceoA, 1);
    edgeDrive(); ceA = 0;
    @(negedge clk); chk(!ceoA && !oeA, "R6 follows ce low", ceoA, 0);
    edgeDrive(); rstOeN = 0;
    @(negedge clk); chk(ceoA, "R6 reset raises ceo", ceoA, 1);
    edgeDrive(); rstOeN = 1; ceA = 1;
    @(negedge clk); chk(ceoA, "R6 ceo stays high", ceoA, 1);
    edgeDrive(); ceA = 0;
    @(negedge clk); chk(ceoA && oeA, "R6 rereading", {ceoA, oeA}, 3);
    runChain(1, 1, 2'd3, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule